// File: doc/BRIEF.md
# Snooping Five-State Line Coherence Controller

This block keeps the coherence state of every line of one direct-mapped cache that shares a snooping bus with other caches. Each line has one of five states: invalid, shared, exclusive, owned or modified. The state is stored as three bits {valid, dirty, shared}. The processor side sends reads, writes and evictions. The block answers each of them in the same cycle with a hit flag and a completion flag, plus at most one bus request: read, read-for-ownership, invalidate or writeback. The new line state is written at the next clock edge.

The snoop side takes the transactions of the other caches. In the same cycle it returns a shared indication and a supply flag. The supply flag says that this cache, and not memory, provides the block. A line that is exclusive becomes modified on a write without any bus traffic. A modified line that another cache reads becomes owned, and it goes on supplying the data. Data arrays, memory and bus arbitration are outside the block.

A snoop and a local request may address the same index in one cycle. The snoop then takes effect and the local request is held off. The processor retries a held-off request, and it also retries a miss that first had to write back a dirty victim.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line reads as invalid. The line state port shows the addressed line's state when its tag matches and invalid otherwise, coded as {valid,dirty,shared}: invalid 3'b000, exclusive 3'b100, shared 3'b101, modified 3'b110, owned 3'b111.
- R2: A local read (cpu_op 0) that misses on a clean or invalid line issues a bus read (bus op 0) with the requested tag and completes. The line becomes exclusive when bus_shared_in is low and shared when it is high.
- R3: A local read that hits a line in shared, exclusive, owned or modified raises cpu_hit, makes no bus request and leaves the state unchanged.
- R4: A snooped bus read (snp_op 0) that matches a valid line raises snp_shared. Exclusive goes to shared and modified goes to owned. Shared and owned stay where they are.
- R5: A snooped bus read or read-for-ownership (snp_op 1) that matches a line in modified or owned raises snp_supply.
- R6: A local write (cpu_op 1) that hits exclusive goes to modified with no bus request. A hit in shared or owned issues an invalidate (bus op 2) and goes to modified. A miss on a clean line issues a read-for-ownership (bus op 1) and goes to modified.
- R7: A snooped read-for-ownership or invalidate (snp_op 2) that matches a valid line moves it to invalid.
- R8: A local eviction (cpu_op 2) of a modified or owned line issues a writeback (bus op 3) and invalidates the line. Evicting a shared or exclusive line invalidates it with no request.
- R9: A local read or write that misses on a modified or owned line with another tag issues a writeback carrying the victim's tag, invalidates the victim and holds cpu_done low. A clean victim is replaced without any writeback.
- R10: A snoop whose tag differs from the stored tag changes no state and raises neither snp_shared nor snp_supply.
- R11: When a snoop and a local request address the same index in one cycle, cpu_ready is low, the local request has no effect and issues no request, and the snoop is applied.
- R12: A snooped writeback (snp_op 3) changes no state and raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_index | input | IDX_W | Line index of the local request |
| cpu_tag | input | TAG_W | Tag of the local request |
| cpu_ready | output | 1 | Low when a snoop addresses the same index |
| cpu_done | output | 1 | Local request completed this cycle |
| cpu_hit | output | 1 | Local request matches a valid line |
| cpu_line_state | output | 3 | State of the addressed line, invalid on tag mismatch |
| bus_req_valid | output | 1 | Bus request issued |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_req_index | output | IDX_W | Index of the bus request |
| bus_req_tag | output | TAG_W | Tag of the bus request |
| bus_shared_in | input | 1 | Another cache holds the block being read |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped bus op, same coding as bus_req_op |
| snp_index | input | IDX_W | Index of the snooped transaction |
| snp_tag | input | TAG_W | Tag of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped block on a read |
| snp_supply | output | 1 | This cache supplies the snooped block |

## Verification
The bench builds two instances with NUM_LINES=4 and TAG_W=4 and wires each one's bus request into the other's snoop port, so that both sides of every transition are seen together. With only four lines, distinct tags on one index are enough to force dirty and clean victim replacement. A third snoop source drives mismatched tags, writebacks and same-index collisions into the first cache while the peer is idle.

// File: rtl/moesi_pkg.sv
// Shared types for the line coherence controller.
// States are coded {valid, dirty, shared}; ops use the bus coding.
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'b000,
        ST_E = 3'b100,
        ST_S = 3'b101,
        ST_M = 3'b110,
        ST_O = 3'b111
    } line_state_e;

    typedef enum logic [1:0] {
        CPU_RD    = 2'd0,
        CPU_WR    = 2'd1,
        CPU_EVICT = 2'd2,
        CPU_NONE  = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BUS_RD  = 2'd0,
        BUS_RDX = 2'd1,
        BUS_INV = 2'd2,
        BUS_WB  = 2'd3
    } bus_op_e;

    // Valid bit of a state code.
    function automatic logic st_valid(input logic [2:0] s);
        return s[2];
    endfunction

    // Dirty bit of a valid state code (modified or owned).
    function automatic logic st_dirty(input logic [2:0] s);
        return s[2] & s[1];
    endfunction

endpackage

// File: rtl/moesi_line_store.sv
// State and tag registers for all lines.
// Two combinational read ports; a local write port that also loads the tag,
// and a snoop write port that changes state only. Assumes NUM_LINES is a
// power of two. The snoop port wins when both hit the same line.
module moesi_line_store #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [2:0]       a_state,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output logic [2:0]       b_state,
    output logic [TAG_W-1:0] b_tag,
    input  logic             la_en,
    input  logic [IDX_W-1:0] la_idx,
    input  logic [2:0]       la_state,
    input  logic [TAG_W-1:0] la_tag,
    input  logic             sn_en,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [2:0]       sn_state
);
    logic [2:0]       st_q [NUM_LINES];
    logic [TAG_W-1:0] tg_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Per-line register update: reset to invalid, snoop first, then local.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= 3'b000;
                tg_q[g] <= '0;
            end else if (sn_en && sn_idx == IDX_W'(g)) begin
                st_q[g] <= sn_state;
            end else if (la_en && la_idx == IDX_W'(g)) begin
                st_q[g] <= la_state;
                tg_q[g] <= la_tag;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tg_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tg_q[b_idx];

endmodule

// File: rtl/moesi_local_ctl.sv
// Next-state and bus-request logic for local processor requests.
// Purely combinational; assumes at most one bus request per cycle and that
// a dirty victim is written back before the miss is serviced (retry).
module moesi_local_ctl
    import moesi_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             req_valid,
    input  logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [2:0]       line_state,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             shared_in,
    output logic             hit,
    output logic             done,
    output logic             bus_valid,
    output logic [1:0]       bus_op,
    output logic [TAG_W-1:0] bus_tag,
    output logic             wr_en,
    output logic [2:0]       wr_state,
    output logic [TAG_W-1:0] wr_tag
);
    logic match;
    logic active;
    logic victim_dirty;

    assign match        = st_valid(line_state) && (line_tag == req_tag);
    assign active       = req_valid && req_ready;
    assign victim_dirty = st_dirty(line_state) && !match;
    assign hit          = req_valid && match;

    // Decide completion, bus request and line update for the local request.
    always_comb begin
        done      = 1'b0;
        bus_valid = 1'b0;
        bus_op    = BUS_RD;
        bus_tag   = req_tag;
        wr_en     = 1'b0;
        wr_state  = line_state;
        wr_tag    = line_tag;
        if (active) begin
            unique case (cpu_op_e'(req_op))
                CPU_RD, CPU_WR: begin
                    if (victim_dirty) begin
                        bus_valid = 1'b1;
                        bus_op    = BUS_WB;
                        bus_tag   = line_tag;
                        wr_en     = 1'b1;
                        wr_state  = ST_I;
                    end else if (match) begin
                        done = 1'b1;
                        if (cpu_op_e'(req_op) == CPU_WR) begin
                            wr_en    = 1'b1;
                            wr_state = ST_M;
                            if (line_state == ST_S || line_state == ST_O) begin
                                bus_valid = 1'b1;
                                bus_op    = BUS_INV;
                            end
                        end
                    end else begin
                        done      = 1'b1;
                        bus_valid = 1'b1;
                        wr_en     = 1'b1;
                        wr_tag    = req_tag;
                        if (cpu_op_e'(req_op) == CPU_WR) begin
                            bus_op   = BUS_RDX;
                            wr_state = ST_M;
                        end else begin
                            bus_op   = BUS_RD;
                            wr_state = shared_in ? ST_S : ST_E;
                        end
                    end
                end
                CPU_EVICT: begin
                    done = 1'b1;
                    if (match) begin
                        wr_en    = 1'b1;
                        wr_state = ST_I;
                        if (st_dirty(line_state)) begin
                            bus_valid = 1'b1;
                            bus_op    = BUS_WB;
                        end
                    end
                end
                default: begin
                    done = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/moesi_snoop_ctl.sv
// Response and next-state logic for snooped bus transactions.
// Purely combinational; a transaction whose tag does not match a valid
// line produces no response and no update.
module moesi_snoop_ctl
    import moesi_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [2:0]       line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             shared,
    output logic             supply,
    output logic             wr_en,
    output logic [2:0]       wr_state
);
    logic match;

    assign match = snp_valid && st_valid(line_state) && (line_tag == snp_tag);

    // Produce the snoop responses and the demoted state of the line.
    always_comb begin
        shared   = 1'b0;
        supply   = 1'b0;
        wr_en    = 1'b0;
        wr_state = line_state;
        if (match) begin
            unique case (bus_op_e'(snp_op))
                BUS_RD: begin
                    shared = 1'b1;
                    supply = st_dirty(line_state);
                    if (line_state == ST_E) begin
                        wr_en    = 1'b1;
                        wr_state = ST_S;
                    end else if (line_state == ST_M) begin
                        wr_en    = 1'b1;
                        wr_state = ST_O;
                    end
                end
                BUS_RDX: begin
                    supply   = st_dirty(line_state);
                    wr_en    = 1'b1;
                    wr_state = ST_I;
                end
                BUS_INV: begin
                    wr_en    = 1'b1;
                    wr_state = ST_I;
                end
                default: begin
                    wr_en = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
// Top of the line coherence controller for one direct-mapped cache.
// Joins the line store with the local and snoop controllers and holds off
// a local request whose index collides with a snoop in the same cycle.
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_index,
    input  logic [TAG_W-1:0] cpu_tag,
    output logic             cpu_ready,
    output logic             cpu_done,
    output logic             cpu_hit,
    output logic [2:0]       cpu_line_state,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_op,
    output logic [IDX_W-1:0] bus_req_index,
    output logic [TAG_W-1:0] bus_req_tag,
    input  logic             bus_shared_in,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_index,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_shared,
    output logic             snp_supply
);
    logic [2:0]       loc_state;
    logic [TAG_W-1:0] loc_tag;
    logic [2:0]       snp_line_state;
    logic [TAG_W-1:0] snp_line_tag;
    logic             loc_wr_en;
    logic [2:0]       loc_wr_state;
    logic [TAG_W-1:0] loc_wr_tag;
    logic             snp_wr_en;
    logic [2:0]       snp_wr_state;

    assign cpu_ready      = !(snp_valid && snp_index == cpu_index);
    assign bus_req_index  = cpu_index;
    assign cpu_line_state = (st_valid(loc_state) && loc_tag == cpu_tag) ? loc_state : ST_I;

    moesi_line_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (cpu_index),
        .a_state (loc_state),
        .a_tag   (loc_tag),
        .b_idx   (snp_index),
        .b_state (snp_line_state),
        .b_tag   (snp_line_tag),
        .la_en   (loc_wr_en),
        .la_idx  (cpu_index),
        .la_state(loc_wr_state),
        .la_tag  (loc_wr_tag),
        .sn_en   (snp_wr_en),
        .sn_idx  (snp_index),
        .sn_state(snp_wr_state)
    );

    moesi_local_ctl #(
        .TAG_W(TAG_W)
    ) u_local (
        .req_valid (cpu_valid),
        .req_ready (cpu_ready),
        .req_op    (cpu_op),
        .req_tag   (cpu_tag),
        .line_state(loc_state),
        .line_tag  (loc_tag),
        .shared_in (bus_shared_in),
        .hit       (cpu_hit),
        .done      (cpu_done),
        .bus_valid (bus_req_valid),
        .bus_op    (bus_req_op),
        .bus_tag   (bus_req_tag),
        .wr_en     (loc_wr_en),
        .wr_state  (loc_wr_state),
        .wr_tag    (loc_wr_tag)
    );

    moesi_snoop_ctl #(
        .TAG_W(TAG_W)
    ) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (snp_op),
        .snp_tag   (snp_tag),
        .line_state(snp_line_state),
        .line_tag  (snp_line_tag),
        .shared    (snp_shared),
        .supply    (snp_supply),
        .wr_en     (snp_wr_en),
        .wr_state  (snp_wr_state)
    );

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
// Port-level protocol checks for the line coherence controller, bound
// into every instance of the top module.
module moesi_line_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_valid,
    input logic [1:0]       cpu_op,
    input logic             cpu_ready,
    input logic             cpu_done,
    input logic             cpu_hit,
    input logic [2:0]       cpu_line_state,
    input logic             bus_req_valid,
    input logic [1:0]       bus_req_op,
    input logic             snp_valid,
    input logic [1:0]       snp_op,
    input logic [IDX_W-1:0] snp_index,
    input logic [IDX_W-1:0] cpu_index,
    input logic             snp_shared,
    input logic             snp_supply
);
    // R3: a read hit stays off the bus.
    p_read_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_op == 2'd0 && cpu_hit) |-> !bus_req_valid);

    // R6: a write to an exclusive line completes without bus traffic.
    p_excl_write_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_op == 2'd1 && cpu_line_state == 3'b100)
        |-> (!bus_req_valid && cpu_done));

    // R5: data is supplied only in answer to a snooped read or read-for-ownership.
    p_supply_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_op == 2'd0 || snp_op == 2'd1)));

    // R4: the shared response answers only a snooped read.
    p_shared_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_op == 2'd0));

    // R11: a held-off request neither completes nor reaches the bus.
    p_collision_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_index == cpu_index) |-> (!cpu_ready && !cpu_done && !bus_req_valid));

    // R9: a miss that writes back its victim does not complete.
    p_victim_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_op != 2'd2 && !cpu_hit && bus_req_valid && bus_req_op == 2'd3)
        |-> !cpu_done);

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_op        (cpu_op),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .cpu_hit       (cpu_hit),
    .cpu_line_state(cpu_line_state),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .snp_valid     (snp_valid),
    .snp_op        (snp_op),
    .snp_index     (snp_index),
    .cpu_index     (cpu_index),
    .snp_shared    (snp_shared),
    .snp_supply    (snp_supply)
);

// File: tb/moesi_line_ctrl_tb.sv
// Two-cache directed bench: u_dut and u_peer snoop each other's requests;
// an extra snoop source drives u_dut while the peer is idle.
module moesi_line_ctrl_tb;
    localparam int NL = 4;
    localparam int TW = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Local request drivers.
    logic          d_cv = 0, p_cv = 0;
    logic [1:0]    d_cop = 0, p_cop = 0;
    logic [IW-1:0] d_cidx = 0, p_cidx = 0;
    logic [TW-1:0] d_ctag = 0, p_ctag = 0;
    // Extra snoop source for u_dut.
    logic          x_v = 0;
    logic [1:0]    x_op = 0;
    logic [IW-1:0] x_idx = 0;
    logic [TW-1:0] x_tag = 0;

    logic          d_rdy, d_done, d_hit, d_rv, d_shr, d_sup;
    logic [2:0]    d_st;
    logic [1:0]    d_rop;
    logic [IW-1:0] d_ridx;
    logic [TW-1:0] d_rtag;
    logic          p_rdy, p_done, p_hit, p_rv, p_shr, p_sup;
    logic [2:0]    p_st;
    logic [1:0]    p_rop;
    logic [IW-1:0] p_ridx;
    logic [TW-1:0] p_rtag;

    logic          ds_v;
    logic [1:0]    ds_op;
    logic [IW-1:0] ds_idx;
    logic [TW-1:0] ds_tag;
    assign ds_v   = p_rv | x_v;
    assign ds_op  = p_rv ? p_rop  : x_op;
    assign ds_idx = p_rv ? p_ridx : x_idx;
    assign ds_tag = p_rv ? p_rtag : x_tag;

    moesi_line_ctrl #(.NUM_LINES(NL), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(d_cv), .cpu_op(d_cop), .cpu_index(d_cidx), .cpu_tag(d_ctag),
        .cpu_ready(d_rdy), .cpu_done(d_done), .cpu_hit(d_hit), .cpu_line_state(d_st),
        .bus_req_valid(d_rv), .bus_req_op(d_rop), .bus_req_index(d_ridx), .bus_req_tag(d_rtag),
        .bus_shared_in(p_shr),
        .snp_valid(ds_v), .snp_op(ds_op), .snp_index(ds_idx), .snp_tag(ds_tag),
        .snp_shared(d_shr), .snp_supply(d_sup)
    );

    moesi_line_ctrl #(.NUM_LINES(NL), .TAG_W(TW)) u_peer (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(p_cv), .cpu_op(p_cop), .cpu_index(p_cidx), .cpu_tag(p_ctag),
        .cpu_ready(p_rdy), .cpu_done(p_done), .cpu_hit(p_hit), .cpu_line_state(p_st),
        .bus_req_valid(p_rv), .bus_req_op(p_rop), .bus_req_index(p_ridx), .bus_req_tag(p_rtag),
        .bus_shared_in(d_shr),
        .snp_valid(d_rv), .snp_op(d_rop), .snp_index(d_ridx), .snp_tag(d_rtag),
        .snp_shared(p_shr), .snp_supply(p_sup)
    );

    // Values captured in the request cycle.
    int c_rv, c_rop, c_rtag, c_done, c_hit, c_rdy, c_dshr, c_dsup;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; capture the issuing side's outputs.
    task automatic step(input bit from_peer);
        #2;
        c_rv   = from_peer ? p_rv   : d_rv;
        c_rop  = from_peer ? p_rop  : d_rop;
        c_rtag = from_peer ? p_rtag : d_rtag;
        c_done = from_peer ? p_done : d_done;
        c_hit  = from_peer ? p_hit  : d_hit;
        c_rdy  = from_peer ? p_rdy  : d_rdy;
        c_dshr = d_shr;
        c_dsup = d_sup;
        @(posedge clk);
        @(negedge clk);
        d_cv = 0; p_cv = 0; x_v = 0;
    endtask

    task automatic cpu(input bit on_peer, input int op, input int idx, input int tag);
        if (on_peer) begin
            p_cv = 1; p_cop = 2'(op); p_cidx = IW'(idx); p_ctag = TW'(tag);
        end else begin
            d_cv = 1; d_cop = 2'(op); d_cidx = IW'(idx); d_ctag = TW'(tag);
        end
        step(on_peer);
    endtask

    task automatic ext(input int op, input int idx, input int tag);
        x_v = 1; x_op = 2'(op); x_idx = IW'(idx); x_tag = TW'(tag);
        step(1'b0);
    endtask

    // Look up a line's state with no request asserted.
    task automatic probe(input bit on_peer, input int idx, input int tag, output int st);
        if (on_peer) begin p_cidx = IW'(idx); p_ctag = TW'(tag); end
        else begin d_cidx = IW'(idx); d_ctag = TW'(tag); end
        #1;
        st = on_peer ? int'(p_st) : int'(d_st);
    endtask

    task automatic t_reset();
        int s;
        probe(0, 0, 0, s); check("R1 dut reset invalid", s, 0);
        probe(1, 3, 0, s); check("R1 peer reset invalid", s, 0);
    endtask

    task automatic t_read_paths();
        int s;
        cpu(0, 0, 1, 3);
        check("R2 miss issues bus read", c_rv * 10 + c_rop, 10);
        check("R2 miss completes", c_done, 1);
        probe(0, 1, 3, s); check("R2 lone reader exclusive", s, 4);
        cpu(0, 0, 1, 3);
        check("R3 hit no request", c_rv, 0);
        check("R3 hit flag", c_hit, 1);
        probe(0, 1, 3, s); check("R3 state kept", s, 4);
        cpu(1, 0, 1, 3);
        check("R4 snooped read shared", c_dshr, 1);
        check("R5 exclusive holder no supply", c_dsup, 0);
        probe(1, 1, 3, s); check("R2 second reader shared", s, 5);
        probe(0, 1, 3, s); check("R4 exclusive to shared", s, 5);
    endtask

    task automatic t_owner();
        int s;
        cpu(0, 1, 1, 3);
        check("R6 shared write invalidates", c_rv * 10 + c_rop, 12);
        probe(1, 1, 3, s); check("R7 peer copy invalidated", s, 0);
        probe(0, 1, 3, s); check("R6 shared to modified", s, 6);
        cpu(1, 0, 1, 3);
        check("R5 modified holder supplies", c_dsup, 1);
        probe(0, 1, 3, s); check("R4 modified to owned", s, 7);
        probe(1, 1, 3, s); check("R2 reader of owned shared", s, 5);
        cpu(0, 0, 1, 3);
        check("R3 owned read hit quiet", c_rv, 0);
        cpu(0, 1, 1, 3);
        check("R6 owned write invalidates", c_rv * 10 + c_rop, 12);
        probe(0, 1, 3, s); check("R6 owned to modified", s, 6);
        probe(1, 1, 3, s); check("R7 peer shared invalidated", s, 0);
    endtask

    task automatic t_write_miss_victims();
        int s;
        cpu(0, 0, 2, 5);
        cpu(0, 1, 2, 5);
        check("R6 exclusive write silent", c_rv, 0);
        probe(0, 2, 5, s); check("R6 exclusive to modified", s, 6);
        cpu(1, 1, 2, 5);
        check("R6 write miss read-for-ownership", c_rv * 10 + c_rop, 11);
        check("R5 supply on ownership read", c_dsup, 1);
        probe(0, 2, 5, s); check("R7 ownership read invalidates", s, 0);
        probe(1, 2, 5, s); check("R6 write miss modified", s, 6);
        cpu(1, 0, 2, 6);
        check("R9 dirty victim writeback", c_rv * 10 + c_rop, 13);
        check("R9 writeback carries victim tag", c_rtag, 5);
        check("R9 not done", c_done, 0);
        probe(1, 2, 5, s); check("R9 victim invalid", s, 0);
        cpu(1, 0, 2, 6);
        check("R9 retry reads", c_rv * 10 + c_rop + c_done * 100, 110);
        cpu(1, 0, 2, 7);
        check("R9 clean victim read direct", c_rv * 10 + c_rop + c_done * 100, 110);
        probe(1, 2, 6, s); check("R9 clean victim replaced", s, 0);
        probe(1, 2, 7, s); check("R2 new line exclusive", s, 4);
    endtask

    task automatic t_evict();
        int s;
        cpu(0, 2, 1, 3);
        check("R8 dirty evict writeback", c_rv * 10 + c_rop, 13);
        probe(0, 1, 3, s); check("R8 dirty evicted invalid", s, 0);
        cpu(0, 0, 3, 1);
        cpu(0, 2, 3, 1);
        check("R8 clean evict quiet", c_rv, 0);
        probe(0, 3, 1, s); check("R8 clean evicted invalid", s, 0);
    endtask

    task automatic t_snoop_corners();
        int s;
        cpu(0, 0, 0, 2);
        ext(1, 0, 9);
        check("R10 mismatch no response", c_dshr * 10 + c_dsup, 0);
        probe(0, 0, 2, s); check("R10 mismatch unchanged", s, 4);
        cpu(0, 1, 0, 2);
        ext(3, 0, 2);
        check("R12 writeback no response", c_dshr * 10 + c_dsup, 0);
        probe(0, 0, 2, s); check("R12 writeback unchanged", s, 6);
        x_v = 1; x_op = 2'd0; x_idx = 2'd0; x_tag = 4'd2;
        d_cv = 1; d_cop = 2'd2; d_cidx = 2'd0; d_ctag = 4'd2;
        step(1'b0);
        check("R11 ready low", c_rdy, 0);
        check("R11 no request", c_rv * 10 + c_done, 0);
        probe(0, 0, 2, s); check("R11 snoop applied evict ignored", s, 7);
        ext(2, 0, 2);
        probe(0, 0, 2, s); check("R7 invalidate to invalid", s, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_paths();
        t_owner();
        t_write_miss_victims();
        t_evict();
        t_snoop_corners();
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

endmodule